// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It walks a two-level translation table held in memory. A request carries the virtual address, a write flag and a user flag. The table base and the domain control word are sampled together with the request.

The walker reads one or two descriptor words through a single read port. It then returns one of two results:
- the physical address together with the cacheable and bufferable attributes, or
- a fault code.

The walker handles four mapping sizes: 1 MB sections, 64 KB large pages, 4 KB small pages and 1 KB tiny pages. Domain and access-permission checks are part of the walk.

The block holds one walk at a time. It takes a new request only when it is idle. The memory port holds `fetch_req` and `fetch_addr` steady until `fetch_valid` returns the word in `fetch_data`. Each completed walk is marked by a single-cycle `done_valid`.

Top module: `mmu_table_walker`

## Requirements
- R1: The first-level fetch address is `{table_base[31:14], va[31:20], 2'b00}`.
- R2: A first-level descriptor whose bits [1:0] are 00 ends the walk with fault code 4'h5 (section translation).
- R3: A first-level descriptor of type 10 is a section. Its bits [31:20] form the physical address together with va[19:0]. Bit 3 gives cacheable and bit 2 gives bufferable. Its domain is in bits [8:5] and its permission is in bits [11:10].
- R4: Type 01 is a coarse table. Its second-level fetch address is `{desc[31:10], va[19:12], 2'b00}`. Type 11 is a fine table, fetched at `{desc[31:12], va[19:10], 2'b00}`. In both cases the domain comes from first-level bits [8:5].
- R5: A second-level descriptor with bits [1:0] equal to 00 gives fault 4'h7 (page translation). Type 11 (tiny) found through a coarse table also gives fault 4'h7.
- R6: Second-level type 01 is a large page, with physical address `{desc[31:16], va[15:0]}`. Type 10 is a small page, `{desc[31:12], va[11:0]}`. Type 11 is a tiny page, `{desc[31:10], va[9:0]}`. Bit 3 gives cacheable and bit 2 gives bufferable.
- R7: A page permission is the 2-bit field at bit `4+2*sel`. For a large page `sel` is va[15:14]. For a small page `sel` is va[11:10]. For a tiny page `sel` is 0.
- R8: The domain field is `domain_ctl[2*dom+1:2*dom]`.
  - Field 00 or 10 faults: section 4'h9, page 4'hB.
  - Field 11 skips the permission check.
  - Field 01 applies the permission check.
  - A translation fault takes priority over a domain fault.
- R9: Permission encodings:
  - 00 allows a privileged read only.
  - 01 allows any privileged access.
  - 10 also allows a user read.
  - 11 allows everything.
  - A violation reports 4'hD for a section and 4'hF for a page.
- R10: `walk_ready` is high only when idle, and a request made while busy is ignored. `fetch_req` and `fetch_addr` hold until `fetch_valid`. `done_valid` lasts one cycle. A section or a first-level fault takes exactly one fetch; every other walk takes two.
- R11: When `done_fault` is high, `done_pa` is zero, `done_cacheable` is 0 and `done_bufferable` is 0. `done_code` is nonzero exactly on a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| walk_req | input | 1 | Translation request |
| walk_ready | output | 1 | Idle, request will be taken |
| walk_va | input | 32 | Virtual address |
| walk_write | input | 1 | Access is a write |
| walk_user | input | 1 | Access is unprivileged |
| table_base | input | 32 | First-level table base (bits [31:14] used) |
| domain_ctl | input | 32 | Sixteen 2-bit domain access fields |
| fetch_req | output | 1 | Descriptor read pending |
| fetch_addr | output | 32 | Descriptor word address |
| fetch_valid | input | 1 | Read data returned |
| fetch_data | input | 32 | Descriptor word |
| done_valid | output | 1 | Result valid for one cycle |
| done_pa | output | 32 | Physical address |
| done_cacheable | output | 1 | Cacheable attribute |
| done_bufferable | output | 1 | Bufferable attribute |
| done_fault | output | 1 | Walk ended in a fault |
| done_code | output | 4 | Fault code, 0 when no fault |

## Verification
The hardest cases to reach are those where two conditions coincide:
- a tiny-type descriptor met through a coarse table;
- a client domain combined with a subpage permission field that differs from its neighbours.

The stimulus sweeps 1024 walks. Each walk's index picks the first-level type, the second-level type, the user and write flags, and the domain value. The remaining descriptor bits are hashed, so the four subpage fields differ from one another. The memory returns each word after zero to two wait cycles. While a walk is in flight, the request stays asserted with a different address, and the bench checks that this address never reaches the fetch port or the result.

// File: rtl/mmu_table_walker.sv
module mmu_table_walker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        walk_req,
  output logic        walk_ready,
  input  logic [31:0] walk_va,
  input  logic        walk_write,
  input  logic        walk_user,
  input  logic [31:0] table_base,
  input  logic [31:0] domain_ctl,
  output logic        fetch_req,
  output logic [31:0] fetch_addr,
  input  logic        fetch_valid,
  input  logic [31:0] fetch_data,
  output logic        done_valid,
  output logic [31:0] done_pa,
  output logic        done_cacheable,
  output logic        done_bufferable,
  output logic        done_fault,
  output logic [3:0]  done_code
);
  localparam logic [3:0] F_SEC_XL = 4'h5, F_PG_XL = 4'h7, F_SEC_DOM = 4'h9,
                         F_PG_DOM = 4'hB, F_SEC_AP = 4'hD, F_PG_AP = 4'hF;

  typedef enum logic [1:0] {S_IDLE, S_L1, S_L2, S_RESP} state_t;
  state_t state;

  logic [19:0] va_q;
  logic        wr_q, usr_q, fine_q;
  logic [3:0]  dom_q;
  logic [31:0] dacr_q;

  logic [3:0]  dom_sel, code_n;
  logic [1:0]  dval, ap, sel;
  logic        go_l2, c_n, b_n, ap_ok;
  logic [31:0] pa_n, l2_addr;
  logic        unused_base;

  assign unused_base = ^table_base[13:0];
  assign walk_ready  = (state == S_IDLE);
  assign fetch_req   = (state == S_L1) || (state == S_L2);
  assign done_valid  = (state == S_RESP);
  assign done_fault  = (done_code != 4'h0);

  function automatic logic perm_ok(input logic [1:0] a, input logic u, input logic w);
    case (a)
      2'b00:   perm_ok = !u && !w;
      2'b01:   perm_ok = !u;
      2'b10:   perm_ok = !u || !w;
      default: perm_ok = 1'b1;
    endcase
  endfunction

  always_comb begin
    dom_sel = (state == S_L1) ? fetch_data[8:5] : dom_q;
    dval    = dacr_q[{dom_sel, 1'b0} +: 2];
    go_l2   = 1'b0;
    code_n  = 4'h0;
    pa_n    = 32'h0;
    c_n     = 1'b0;
    b_n     = 1'b0;
    sel     = 2'b00;
    ap      = 2'b00;
    l2_addr = fetch_data[1] ? {fetch_data[31:12], va_q[19:10], 2'b00}
                            : {fetch_data[31:10], va_q[19:12], 2'b00};
    if (state == S_L1) begin
      ap = fetch_data[11:10];
      case (fetch_data[1:0])
        2'b00: code_n = F_SEC_XL;
        2'b10: begin
          if (!dval[0])                                    code_n = F_SEC_DOM;
          else if (!dval[1] && !perm_ok(ap, usr_q, wr_q))  code_n = F_SEC_AP;
          else begin
            pa_n = {fetch_data[31:20], va_q[19:0]};
            c_n  = fetch_data[3];
            b_n  = fetch_data[2];
          end
        end
        default: go_l2 = 1'b1;
      endcase
    end else begin
      case (fetch_data[1:0])
        2'b01:   sel = va_q[15:14];
        2'b10:   sel = va_q[11:10];
        default: sel = 2'b00;
      endcase
      ap = fetch_data[{sel, 1'b0} + 5'd4 +: 2];
      if (fetch_data[1:0] == 2'b00 || (fetch_data[1:0] == 2'b11 && !fine_q))
        code_n = F_PG_XL;
      else if (!dval[0])                               code_n = F_PG_DOM;
      else if (!dval[1] && !perm_ok(ap, usr_q, wr_q))  code_n = F_PG_AP;
      else begin
        case (fetch_data[1:0])
          2'b01:   pa_n = {fetch_data[31:16], va_q[15:0]};
          2'b10:   pa_n = {fetch_data[31:12], va_q[11:0]};
          default: pa_n = {fetch_data[31:10], va_q[9:0]};
        endcase
        c_n = fetch_data[3];
        b_n = fetch_data[2];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      va_q <= '0; wr_q <= 1'b0; usr_q <= 1'b0; fine_q <= 1'b0;
      dom_q <= '0; dacr_q <= '0; fetch_addr <= '0;
      done_pa <= '0; done_cacheable <= 1'b0; done_bufferable <= 1'b0;
      done_code <= '0;
    end else begin
      case (state)
        S_IDLE: if (walk_req) begin
          va_q       <= walk_va[19:0];
          wr_q       <= walk_write;
          usr_q      <= walk_user;
          dacr_q     <= domain_ctl;
          fetch_addr <= {table_base[31:14], walk_va[31:20], 2'b00};
          state      <= S_L1;
        end
        S_L1, S_L2: if (fetch_valid) begin
          if (go_l2) begin
            fine_q     <= fetch_data[1];
            dom_q      <= fetch_data[8:5];
            fetch_addr <= l2_addr;
            state      <= S_L2;
          end else begin
            done_pa         <= pa_n;
            done_cacheable  <= c_n;
            done_bufferable <= b_n;
            done_code       <= code_n;
            state           <= S_RESP;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_fetch_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req && !fetch_valid |=> fetch_req && $stable(fetch_addr));
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid);
  p_fetch_after_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fetch_req) |-> $past(walk_req && walk_ready));
  p_fault_clean_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && done_fault |-> done_pa == 32'h0 && !done_cacheable && !done_bufferable);
  p_busy_not_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> !walk_ready);
endmodule

// File: tb/mmu_table_walker_bench.sv
module mmu_table_walker_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic walk_req = 1'b0, walk_write = 1'b0, walk_user = 1'b0;
  logic [31:0] walk_va = '0, table_base = '0, domain_ctl = '0;
  logic fetch_valid = 1'b0;
  logic [31:0] fetch_data = '0;
  logic walk_ready, fetch_req, done_valid, done_cacheable, done_bufferable, done_fault;
  logic [31:0] fetch_addr, done_pa;
  logic [3:0] done_code;
  int checks = 0, failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  mmu_table_walker u_mmu_table_walker (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mix(input int n);
    logic [31:0] x;
    x = n * 32'h9E3779B1;
    x = x ^ (x >> 15);
    x = x * 32'h85EBCA6B;
    return x ^ (x >> 13);
  endfunction

  function automatic bit pok(input logic [1:0] a, input bit u, input bit w);
    return (a == 2'b11) || (a == 2'b10 && !(u && w)) || (a == 2'b01 && !u) || (a == 2'b00 && !u && !w);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk(walk_ready == 1'b1 && fetch_req == 1'b0 && done_valid == 1'b0, "R10 reset",
        {29'b0, walk_ready, fetch_req, done_valid}, 32'h4);
    rst_n = 1'b1;
    for (int i = 0; i < 1024; i++) begin
      logic [31:0] va, l1, l2, dacr, l1a, l2a, epa;
      logic [3:0] ecode, dom;
      logic [1:0] dval, t1, t2, sel, ap;
      logic ec, eb;
      bit u, w;
      int nf, fetches, lat, waitc, guard;
      bit done;
      va = mix(i); t1 = i[1:0]; t2 = i[3:2]; u = i[4]; w = i[5]; dval = i[7:6];
      l1 = {mix(i + 5000)[31:2], t1};
      l2 = {mix(i + 9000)[31:2], t2};
      dom = l1[8:5];
      dacr = mix(i + 13000);
      dacr[2*dom +: 2] = dval;
      table_base = mix(i + 17000);
      lat = i % 3;
      l1a = {table_base[31:14], va[31:20], 2'b00};
      l2a = t1[1] ? {l1[31:12], va[19:10], 2'b00} : {l1[31:10], va[19:12], 2'b00};
      epa = 0; ec = 0; eb = 0; ecode = 0; nf = 1;
      if (t1 == 2'b00) ecode = 4'h5;
      else if (t1 == 2'b10) begin
        if (dval == 2'b00 || dval == 2'b10) ecode = 4'h9;
        else if (dval == 2'b01 && !pok(l1[11:10], u, w)) ecode = 4'hD;
        else begin epa = {l1[31:20], va[19:0]}; ec = l1[3]; eb = l1[2]; end
      end else begin
        nf = 2;
        sel = (t2 == 2'b01) ? va[15:14] : (t2 == 2'b10) ? va[11:10] : 2'b00;
        ap = l2[4 + 2*sel +: 2];
        if (t2 == 2'b00 || (t2 == 2'b11 && t1 == 2'b01)) ecode = 4'h7;
        else if (dval == 2'b00 || dval == 2'b10) ecode = 4'hB;
        else if (dval == 2'b01 && !pok(ap, u, w)) ecode = 4'hF;
        else begin
          epa = (t2 == 2'b01) ? {l2[31:16], va[15:0]} :
                (t2 == 2'b10) ? {l2[31:12], va[11:0]} : {l2[31:10], va[9:0]};
          ec = l2[3]; eb = l2[2];
        end
      end
      @(negedge clk);
      walk_req = 1'b1; walk_va = va; walk_user = u; walk_write = w; domain_ctl = dacr;
      fetches = 0; waitc = 0; done = 0; guard = 0;
      while (!done && guard < 50) begin
        @(negedge clk);
        guard++;
        fetch_valid = 1'b0;
        walk_va = ~va; walk_user = ~u; domain_ctl = ~dacr;
        if (done_valid) begin
          walk_req = 1'b0; done = 1;
          chk(fetches == nf, "R10 fetch count", fetches, nf);
          chk(done_code == ecode, "R2 R5 R8 R9 fault code", done_code, ecode);
          chk(done_fault == (ecode != 0), "R11 fault flag", done_fault, ecode != 0);
          chk(done_pa == epa, "R3 R6 R7 physical address", done_pa, epa);
          chk({done_cacheable, done_bufferable} == {ec, eb}, "R3 R6 attributes",
              {done_cacheable, done_bufferable}, {ec, eb});
        end else if (fetch_req) begin
          if (waitc < lat) waitc++;
          else begin
            if (fetches == 0) chk(fetch_addr == l1a, "R1 first-level address", fetch_addr, l1a);
            else chk(fetch_addr == l2a, "R4 second-level address", fetch_addr, l2a);
            fetch_data = (fetches == 0) ? l1 : l2;
            fetch_valid = 1'b1;
            fetches++;
            waitc = 0;
          end
        end
      end
      if (!done) chk(1'b0, "R10 walk completes", 0, 1);
      @(negedge clk);
      chk(walk_ready && !done_valid, "R10 idle after done", {walk_ready, done_valid}, 2'b10);
    end
    finished = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000 && !finished; c++) @(posedge clk);
    if (!finished) chk(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule